// File: doc/BRIEF.md
# PWM Compare and Output Action Unit

This block turns a running time-base count into two pulse-width-modulated outputs, A and B. It compares the count against two compare values and watches the zero and period strobes from the time base. On each such event, the programmed action for each output decides whether that output is held, driven low, driven high or inverted. The outputs are registered, so an event seen at one clock edge shows on the pins after that edge.

Software writes five registers through a simple write port: a compare control register, the two compare values and one action register per output. Each compare value either takes effect on the cycle after the write, or waits in a shadow copy until a chosen time-base event moves it across. This lets a new duty cycle start cleanly at a period boundary. A write of a compare value above the current period is dropped.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, both compare values read as zero, and all action fields hold code 0.
- R2: Action codes work as follows: 0 leaves the output unchanged, 1 drives it low, 2 drives it high and 3 inverts it. The result appears on the output one clock after the event.
- R3: In each action register, bits 1:0 hold the action for the zero event, bits 5:4 the action for a compare A up-match and bits 9:8 the action for a compare B up-match.
- R4: A compare up-match needs two things: the count equals that compare value, and `cnt_up_i` is high. While the count runs down, no compare action occurs.
- R5: When several events hit one output on the same cycle, the order is fixed. Compare B wins over compare A, and compare A wins over zero. An event whose code is 0 takes no part in this choice.
- R6: Bit 4 (compare A) and bit 6 (compare B) of the compare control register choose the load mode: 0 means immediate, 1 means shadowed. In immediate mode an accepted write shows on the compare output on the next cycle.
- R7: In shadowed mode a write goes to the shadow copy. The shadow copy moves to the active compare value on an event picked by a 2-bit field: bits 1:0 for A, bits 3:2 for B. The codes are 0 for zero, 1 for period and 2 for either. If a transfer and a write fall on the same cycle, the old shadow value is transferred.
- R8: Load timing code 3 freezes a shadowed compare value: no event ever changes it.
- R9: A compare write whose value is greater than `period_i` is dropped, and the active value does not change. A value equal to the period is accepted.
- R10: If an output is set on zero and cleared on its compare up-match, its high time equals the compare value in counter ticks. A compare value of 0 keeps the output low.
- R11: Writes use `addr_i` as follows: 0 compare control, 1 compare A, 2 compare B, 3 action A, 4 action B. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Time-base count value |
| cnt_up_i | input | 1 | Time base is counting up |
| cnt_zero_i | input | 1 | Count-equals-zero strobe |
| cnt_prd_i | input | 1 | Count-equals-period strobe |
| period_i | input | CNT_W | Current period, the upper bound for compare writes |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 16 | Write data |
| pwm_a_o | output | 1 | Output A |
| pwm_b_o | output | 1 | Output B |
| cmp_a_o | output | CNT_W | Active compare A value |
| cmp_b_o | output | CNT_W | Active compare B value |

## Verification
The hardest case to reach from the ports is a shadow write that lands on the same cycle as a shadow transfer. The stimulus drives the count from the bench and issues a write exactly on the cycle that carries the zero strobe, then reads back the active value. The bench also lines up coincident events for the priority rule by setting both compare values equal, and for the zero-duty case by setting compare A to 0. Only this way do the zero event and the match event fall on one tick.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int REG_W = 16;
  localparam int ADDR_W = 3;
  localparam int NCH = 2;
  localparam int NEV = 3;  // zero, compare A up, compare B up

  typedef enum logic [1:0] {ACT_NONE = 2'd0, ACT_CLR = 2'd1, ACT_SET = 2'd2, ACT_TGL = 2'd3} act_e;
  typedef enum logic [1:0] {LD_ZERO = 2'd0, LD_PRD = 2'd1, LD_EITHER = 2'd2, LD_FREEZE = 2'd3} ld_e;

  localparam logic [ADDR_W-1:0] ADDR_CMPCTL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP [NCH] = '{3'd1, 3'd2};
  localparam logic [ADDR_W-1:0] ADDR_ACT [NCH] = '{3'd3, 3'd4};

  localparam int SHDW_BIT [NCH] = '{4, 6};
  localparam int LDM_LSB  [NCH] = '{0, 2};
  localparam int ACT_LSB  [NEV] = '{0, 4, 8};
endpackage

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shadow_en_i,
  input  ld_e              ld_mode_i,
  input  logic             zero_i,
  input  logic             prd_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cmp_q, shadow_q;
  logic wr_ok, ld_ev;

  assign wr_ok = wr_i && (wdata_i <= limit_i);

  always_comb begin
    unique case (ld_mode_i)
      LD_ZERO:   ld_ev = zero_i;
      LD_PRD:    ld_ev = prd_i;
      LD_EITHER: ld_ev = zero_i | prd_i;
      default:   ld_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q    <= '0;
      shadow_q <= '0;
    end else if (shadow_en_i) begin
      if (ld_ev) cmp_q <= shadow_q;   // old shadow wins on a coincident write
      if (wr_ok) shadow_q <= wdata_i;
    end else if (wr_ok) begin
      cmp_q <= wdata_i;
    end
  end

  assign cmp_o   = cmp_q;
  assign match_o = up_i && (cnt_i == cmp_q);

  p_imm_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shadow_en_i && wr_i && wdata_i <= limit_i) |=> (cmp_o == $past(wdata_i)));
  p_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shadow_en_i && wr_i && wdata_i > limit_i) |=> $stable(cmp_o));
  p_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shadow_en_i && ld_mode_i == LD_FREEZE) |=> $stable(cmp_o));
endmodule

// File: rtl/pwm_out_unit.sv
module pwm_out_unit
  import pwm_aq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NEV-1:0]   ev_i,
  input  logic [REG_W-1:0] ctl_i,
  output logic             out_o
);
  logic [1:0] code [NEV];
  act_e sel;
  logic out_q, out_d;

  for (genvar k = 0; k < NEV; k++) begin : g_code
    assign code[k] = ctl_i[ACT_LSB[k] +: 2];
  end

  // later events take priority: compare B > compare A > zero
  always_comb begin
    sel = ACT_NONE;
    for (int k = 0; k < NEV; k++)
      if (ev_i[k] && code[k] != 2'd0) sel = act_e'(code[k]);
  end

  always_comb begin
    unique case (sel)
      ACT_CLR: out_d = 1'b0;
      ACT_SET: out_d = 1'b1;
      ACT_TGL: out_d = ~out_q;
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  p_cmpb_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i[2] && ctl_i[9:8] == 2'd1) |=> !out_o);
  p_prio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i[2] && ev_i[1] && ctl_i[9:8] == 2'd2 && ctl_i[5:4] == 2'd1) |=> out_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ev_i[0] && ctl_i[1:0] != 2'd0) && !(ev_i[1] && ctl_i[5:4] != 2'd0) &&
     !(ev_i[2] && ctl_i[9:8] != 2'd0)) |=> $stable(out_o));
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_up_i,
  input  logic              cnt_zero_i,
  input  logic              cnt_prd_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic [CNT_W-1:0]  cmp_a_o,
  output logic [CNT_W-1:0]  cmp_b_o
);
  logic [REG_W-1:0] cmp_ctl_q;
  logic [REG_W-1:0] act_q [NCH];
  logic [CNT_W-1:0] cmp_val [NCH];
  logic [NCH-1:0]   match, pwm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_ctl_q <= '0;
      for (int i = 0; i < NCH; i++) act_q[i] <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CMPCTL) cmp_ctl_q <= wdata_i;
      for (int i = 0; i < NCH; i++)
        if (addr_i == ADDR_ACT[i]) act_q[i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .shadow_en_i (cmp_ctl_q[SHDW_BIT[g]]),
      .ld_mode_i   (ld_e'(cmp_ctl_q[LDM_LSB[g] +: 2])),
      .zero_i      (cnt_zero_i),
      .prd_i       (cnt_prd_i),
      .wr_i        (wr_i && addr_i == ADDR_CMP[g]),
      .wdata_i     (wdata_i[CNT_W-1:0]),
      .limit_i     (period_i),
      .cnt_i       (cnt_i),
      .up_i        (cnt_up_i),
      .cmp_o       (cmp_val[g]),
      .match_o     (match[g])
    );

    pwm_out_unit u_out (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   ({match[1], match[0], cnt_zero_i}),
      .ctl_i  (act_q[g]),
      .out_o  (pwm[g])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
  assign cmp_a_o = cmp_val[0];
  assign cmp_b_o = cmp_val[1];

  p_down_no_cmp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_up_i && !cnt_zero_i) |=> (pwm_a_o == $past(pwm_a_o) && pwm_b_o == $past(pwm_b_o)));
endmodule

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;
  localparam int CLK_P = 10;
  localparam int W = 16;

  typedef struct {
    logic a;
    logic b;
    logic [W-1:0] ca;
    logic [W-1:0] cb;
    string req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] cnt = '0, period = 16'd9;
  logic up = 0, zero = 0, prd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic pwm_a, pwm_b;
  logic [W-1:0] cmp_a, cmp_b;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  exp_t q[$];

  // reference model state
  logic [15:0] m_ctl = '0;
  logic [15:0] m_act [2] = '{16'd0, 16'd0};
  logic [W-1:0] m_cmp [2] = '{16'd0, 16'd0};
  logic [W-1:0] m_sh [2] = '{16'd0, 16'd0};
  logic m_out [2] = '{1'b0, 1'b0};

  always #(CLK_P/2) clk = ~clk;

  pwm_action_qual #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_up_i(up), .cnt_zero_i(zero),
    .cnt_prd_i(prd), .period_i(period), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: drives one cycle and pushes the expected result
  task automatic step(bit w, logic [2:0] ad, logic [15:0] d, logic [W-1:0] c,
                      bit u, bit z, bit p);
    logic mt [2];
    logic [1:0] code, sel;
    bit shd, lev;
    logic [1:0] lm;
    logic [W-1:0] sh_old;
    exp_t e;
    @(negedge clk);
    wr = w; addr = ad; wdata = d; cnt = c; up = u; zero = z; prd = p;
    for (int i = 0; i < 2; i++) mt[i] = u && (c == m_cmp[i]);
    for (int o = 0; o < 2; o++) begin
      sel = 2'd0;
      code = m_act[o][1:0]; if (z && code != 0) sel = code;
      code = m_act[o][5:4]; if (mt[0] && code != 0) sel = code;
      code = m_act[o][9:8]; if (mt[1] && code != 0) sel = code;
      case (sel)
        2'd1: m_out[o] = 1'b0;
        2'd2: m_out[o] = 1'b1;
        2'd3: m_out[o] = ~m_out[o];
        default: ;
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      shd = m_ctl[i == 0 ? 4 : 6];
      lm = m_ctl[2*i +: 2];
      lev = (lm == 0) ? z : (lm == 1) ? p : (lm == 2) ? (z | p) : 1'b0;
      sh_old = m_sh[i];
      if (w && ad == 3'(i + 1) && d[W-1:0] <= period) begin
        if (shd) m_sh[i] = d[W-1:0];
        else m_cmp[i] = d[W-1:0];
      end
      if (shd && lev) m_cmp[i] = sh_old;
    end
    if (w && ad == 3'd0) m_ctl = d;
    if (w && ad == 3'd3) m_act[0] = d;
    if (w && ad == 3'd4) m_act[1] = d;
    e.a = m_out[0]; e.b = m_out[1]; e.ca = m_cmp[0]; e.cb = m_cmp[1]; e.req = cur_req;
    q.push_back(e);
  endtask

  task automatic wreg(logic [2:0] ad, logic [15:0] d);
    step(1, ad, d, 16'd100, 0, 0, 0);
  endtask

  task automatic idle();
    step(0, 0, 0, 16'd100, 0, 0, 0);
  endtask

  task automatic run_up();
    for (int c = 0; c <= int'(period); c++)
      step(0, 0, 0, W'(c), 1, c == 0, c == int'(period));
  endtask

  task automatic run_down();
    for (int c = int'(period); c >= 0; c--)
      step(0, 0, 0, W'(c), 0, c == 0, c == int'(period));
  endtask

  // monitor: compares each cycle against the scoreboard
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, {30'd0, pwm_a, pwm_b, cmp_a, cmp_b}, {30'd0, e.a, e.b, e.ca, e.cb});
    end
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi;
    #(CLK_P * 2 + 2);
    check("R1", {30'd0, pwm_a, pwm_b, cmp_a, cmp_b}, 64'd0);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; run_up();  // all actions reset to code 0: outputs stay low

    // R3 R10 R11: set on zero, clear on own compare up-match
    cur_req = "R11";
    wreg(3'd3, 16'h0012); wreg(3'd4, 16'h0102);
    wreg(3'd1, 16'd3); wreg(3'd2, 16'd5);
    cur_req = "R10"; run_up(); run_up();
    // direct high-time measurement of output A, R10
    hi = 0;
    fork
      run_up();
      begin
        repeat (int'(period) + 1) begin
          @(posedge clk); #(CLK_P/4);
          if (pwm_a) hi++;
        end
      end
    join
    check("R10 high time", 64'(hi), 64'd3);
    cur_req = "R10"; wreg(3'd1, 16'd0); run_up(); run_up();

    // R4: counting down never matches
    cur_req = "R4"; wreg(3'd1, 16'd4); run_down(); run_down();

    // R2: toggle on compare A, set via compare B field on output A (R3)
    cur_req = "R2"; wreg(3'd3, 16'h0030); run_up(); run_up();
    cur_req = "R3"; wreg(3'd3, 16'h0200); run_up(); wreg(3'd3, 16'h0001); run_up();

    // R5: priority with equal compare values
    cur_req = "R5";
    wreg(3'd1, 16'd2); wreg(3'd2, 16'd2);
    wreg(3'd3, 16'h0212); run_up();
    wreg(3'd3, 16'h0012); run_up();
    wreg(3'd3, 16'h0111); wreg(3'd1, 16'd0); wreg(3'd2, 16'd0); run_up();

    // R6: immediate load
    cur_req = "R6"; wreg(3'd0, 16'h0000); wreg(3'd1, 16'd7); wreg(3'd2, 16'd8); idle();

    // R7: shadow on zero (A) and on period (B), write coinciding with transfer
    cur_req = "R7";
    wreg(3'd0, 16'h0054);
    wreg(3'd1, 16'd1); wreg(3'd2, 16'd6); idle(); run_up();
    wreg(3'd1, 16'd5);
    step(1, 3'd1, 16'd2, 16'd0, 1, 1, 0);
    idle(); run_up();
    wreg(3'd0, 16'h005A); wreg(3'd1, 16'd8); wreg(3'd2, 16'd3); run_down();

    // R8: freeze
    cur_req = "R8"; wreg(3'd0, 16'h005F); wreg(3'd1, 16'd4); wreg(3'd2, 16'd4); run_up(); run_down();

    // R9: reject above period, accept equal to period
    cur_req = "R9"; wreg(3'd0, 16'h0000);
    wreg(3'd1, 16'd12); wreg(3'd2, 16'd10); idle();
    wreg(3'd1, 16'd9); idle();

    // R11: unused addresses ignored
    cur_req = "R11";
    wreg(3'd5, 16'hFFFF); wreg(3'd6, 16'hFFFF); wreg(3'd7, 16'hFFFF); run_up();

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule